// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with One PWM Channel

This block is a general-purpose timer peripheral. Software reaches it through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. A 16-bit divider slows the input clock by the programmed divide value plus one. The divided tick drives a 16-bit counter that climbs to a programmed reload limit, returns to zero and raises an update event. Update and compare events set sticky status flags. Each flag can be routed to a single level-sensitive interrupt line.

Software can force an update at any time. A write to the status register clears only the bits written as zero. One compare channel turns the counter and a compare value into a PWM waveform, in either of two polarities. A new compare value can take effect at once or wait for the next update event. A new divide value always waits for the next update event, so a period already in progress keeps its length.

Top module: `gp_pwm_timer`

Register map (byte addresses, all other addresses read as zero): 0x00 CTRL, 0x04 INTEN, 0x08 STAT, 0x0C EVGEN, 0x10 CHCFG, 0x14 COUNT, 0x18 DIV, 0x1C RELOAD, 0x20 CMP.

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `pwm_o` are low.
- R2: Each mapped register reads back its value at the address in the map above. EVGEN always reads zero, and an address not in the map reads zero. A write replaces the whole stored field and is never merged with the old value.
- R3: While CTRL bit 0 (run) is set, the counter advances once every DIV+1 clocks. A value written to DIV is held in a shadow register and only becomes the active divide value at the next update event.
- R4: The counter returns to zero and signals an update event on the tick where its value is at or above RELOAD. While RELOAD is zero the counter does not advance and no update event comes from counting.
- R5: An update event sets STAT bit 0 when CTRL bit 1 (quiet) is clear. While quiet is set, no update event sets STAT bit 0.
- R6: A write to STAT ANDs the written bits into the flags, so a 0 clears a bit and a 1 keeps it. A flag raised by hardware in the same cycle stays set.
- R7: Writing EVGEN with bit 0 set forces an update event. The counter and the divider phase clear, and the shadowed DIV and CMP values are loaded. Writing EVGEN with bit 0 clear has no effect.
- R8: A write to COUNT loads its low 16 bits into the counter directly.
- R9: STAT bit 1 is set when a counting tick moves the counter onto the active compare value. A wrap to zero counts as such a move.
- R10: `irq_o` is high while STAT bit 0 is set together with INTEN bit 0, or while STAT bit 1 is set together with INTEN bit 1.
- R11: CHCFG bits 2:0 select the output mode. Mode 6 drives `pwm_o` high while COUNT < active compare. Mode 7 drives it high while COUNT >= active compare. Any other mode drives it low. `pwm_o` is low whenever CHCFG bit 4 (output enable) is clear.
- R12: With CHCFG bit 3 (compare preload) set, the active compare value changes only at an update event. With it clear, the active compare value follows CMP one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt |
| pwm_o | output | 1 | Compare channel PWM output |

## Verification
A divider phase that has slipped shows up on COUNT within one period of DIV+1 clocks, as a step landing one cycle early or late. A shadow value loaded at the wrong moment changes the next period's length, or moves the PWM edge, right after the following update. Flag logic that is wrong appears on `irq_o` one clock after the event that should or should not have set it. The reference model is compared against read data, `irq_o` and `pwm_o` on every clock, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int TMR_CNT_W = 16;
  localparam int TMR_ADDR_W = 8;
  localparam int TMR_DATA_W = 32;

  typedef logic [TMR_CNT_W-1:0] tcount_t;

  localparam logic [TMR_ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [TMR_ADDR_W-1:0] A_INTEN  = 8'h04;
  localparam logic [TMR_ADDR_W-1:0] A_STAT   = 8'h08;
  localparam logic [TMR_ADDR_W-1:0] A_EVGEN  = 8'h0C;
  localparam logic [TMR_ADDR_W-1:0] A_CHCFG  = 8'h10;
  localparam logic [TMR_ADDR_W-1:0] A_COUNT  = 8'h14;
  localparam logic [TMR_ADDR_W-1:0] A_DIV    = 8'h18;
  localparam logic [TMR_ADDR_W-1:0] A_RELOAD = 8'h1C;
  localparam logic [TMR_ADDR_W-1:0] A_CMP    = 8'h20;

  typedef enum logic [2:0] {
    OUTM_LOW   = 3'd0,
    OUTM_LEAD  = 3'd6,
    OUTM_TRAIL = 3'd7
  } out_mode_e;

  // next divider phase: wraps at the active limit, holds when stopped
  function automatic tcount_t prescale_step(tcount_t phase, tcount_t limit, logic run);
    if (!run) return phase;
    if (phase == limit) return '0;
    return phase + tcount_t'(1);
  endfunction

  // counting step of the main counter: zero when at or beyond the limit
  function automatic tcount_t count_step(tcount_t cur, tcount_t limit);
    if (cur >= limit) return '0;
    return cur + tcount_t'(1);
  endfunction

  // level of the compare channel for a given mode
  function automatic logic pwm_level(logic [2:0] mode, tcount_t cur, tcount_t cmp);
    case (mode)
      3'd6:    return cur < cmp;
      3'd7:    return cur >= cmp;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int ADDR_W = TMR_ADDR_W,
  parameter int DATA_W = TMR_DATA_W,
  parameter int CNT_W  = TMR_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              upd_evt,
  input  logic              cmp_evt,
  input  logic [CNT_W-1:0]  cnt_val,
  output logic              run,
  output logic              force_upd,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic [CNT_W-1:0]  div_sh,
  output logic [CNT_W-1:0]  reload,
  output logic [CNT_W-1:0]  cmp_sh,
  output logic [2:0]        mode,
  output logic              preload,
  output logic              outen,
  output logic              irq
);
  localparam int NFLAG = 2;
  localparam int PADW  = DATA_W - CNT_W;

  logic             quiet;
  logic [NFLAG-1:0] inten;
  logic [NFLAG-1:0] stat;
  logic [NFLAG-1:0] stat_set;

  logic wr_ctrl, wr_inten, wr_stat, wr_evgen, wr_chcfg, wr_count, wr_div, wr_reload, wr_cmp;

  assign wr_ctrl   = bus_we && (bus_addr == A_CTRL);
  assign wr_inten  = bus_we && (bus_addr == A_INTEN);
  assign wr_stat   = bus_we && (bus_addr == A_STAT);
  assign wr_evgen  = bus_we && (bus_addr == A_EVGEN);
  assign wr_chcfg  = bus_we && (bus_addr == A_CHCFG);
  assign wr_count  = bus_we && (bus_addr == A_COUNT);
  assign wr_div    = bus_we && (bus_addr == A_DIV);
  assign wr_reload = bus_we && (bus_addr == A_RELOAD);
  assign wr_cmp    = bus_we && (bus_addr == A_CMP);

  assign force_upd    = wr_evgen && bus_wdata[0];
  assign cnt_load     = wr_count;
  assign cnt_load_val = bus_wdata[CNT_W-1:0];

  assign stat_set = {cmp_evt, upd_evt && !quiet};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      quiet   <= 1'b0;
      inten   <= '0;
      stat    <= '0;
      mode    <= 3'd0;
      preload <= 1'b0;
      outen   <= 1'b0;
      div_sh  <= '0;
      reload  <= '0;
      cmp_sh  <= '0;
    end else begin
      if (wr_ctrl) begin
        run   <= bus_wdata[0];
        quiet <= bus_wdata[1];
      end
      if (wr_inten) inten <= bus_wdata[NFLAG-1:0];
      if (wr_stat) stat <= (stat & bus_wdata[NFLAG-1:0]) | stat_set;
      else         stat <= stat | stat_set;
      if (wr_chcfg) begin
        mode    <= bus_wdata[2:0];
        preload <= bus_wdata[3];
        outen   <= bus_wdata[4];
      end
      if (wr_div)    div_sh <= bus_wdata[CNT_W-1:0];
      if (wr_reload) reload <= bus_wdata[CNT_W-1:0];
      if (wr_cmp)    cmp_sh <= bus_wdata[CNT_W-1:0];
    end
  end

  assign irq = |(stat & inten);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:   bus_rdata = {{(DATA_W-2){1'b0}}, quiet, run};
      A_INTEN:  bus_rdata = {{(DATA_W-NFLAG){1'b0}}, inten};
      A_STAT:   bus_rdata = {{(DATA_W-NFLAG){1'b0}}, stat};
      A_CHCFG:  bus_rdata = {{(DATA_W-5){1'b0}}, outen, preload, mode};
      A_COUNT:  bus_rdata = {{PADW{1'b0}}, cnt_val};
      A_DIV:    bus_rdata = {{PADW{1'b0}}, div_sh};
      A_RELOAD: bus_rdata = {{PADW{1'b0}}, reload};
      A_CMP:    bus_rdata = {{PADW{1'b0}}, cmp_sh};
      default:  bus_rdata = '0;
    endcase
  end

  AST_FLAG_ON_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_evt && !quiet) |=> stat[0]); // R5
  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !stat[0]) |=> !stat[0]); // R5
  AST_EVGEN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_EVGEN) |-> (bus_rdata == '0)); // R2
  AST_CLEAR_ONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[1] && stat[1]) |=> stat[1]); // R6

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import timer_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             upd_evt,
  input  logic [CNT_W-1:0] div_sh,
  output logic             tick
);
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] limit;

  assign tick = run && (phase == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      limit <= '0;
    end else begin
      if (upd_evt) begin
        phase <= '0;
        limit <= div_sh;
      end else begin
        phase <= prescale_step(phase, limit, run);
      end
    end
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= limit); // R3
  AST_DIV_BUFFERED: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_evt |=> $stable(limit)); // R3

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import timer_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             force_upd,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] cmp_act,
  output logic [CNT_W-1:0] cnt,
  output logic             upd_evt,
  output logic             cmp_evt
);
  logic             adv;
  logic             wrap;
  logic [CNT_W-1:0] step;

  assign adv     = tick && (reload != '0);
  assign step    = count_step(cnt, reload);
  assign wrap    = adv && (cnt >= reload);
  assign upd_evt = wrap || force_upd;
  assign cmp_evt = adv && (step == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (force_upd) cnt <= '0;
    else if (cnt_load)  cnt <= cnt_load_val;
    else if (adv)       cnt <= step;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    upd_evt |=> (cnt == '0)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !wrap && !cnt_load && !force_upd) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_load && !force_upd) |=> $stable(cnt)); // R4

endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
  import timer_pkg::*;
#(
  parameter int CNT_W = TMR_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_evt,
  input  logic             preload,
  input  logic             outen,
  input  logic [2:0]       mode,
  input  logic [CNT_W-1:0] cmp_sh,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_act,
  output logic             pwm
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cmp_act <= '0;
    else if (!preload || upd_evt) cmp_act <= cmp_sh;
  end

  assign pwm = outen && pwm_level(mode, cnt, cmp_act);

  AST_CMP_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (preload && !upd_evt) |=> $stable(cmp_act)); // R12
  AST_PWM_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outen) |-> !pwm); // R11

endmodule

// File: rtl/gp_pwm_timer.sv
module gp_pwm_timer
  import timer_pkg::*;
#(
  parameter int ADDR_W = TMR_ADDR_W,
  parameter int DATA_W = TMR_DATA_W,
  parameter int CNT_W  = TMR_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              pwm_o
);
  logic             run, force_upd, cnt_load, preload, outen;
  logic             tick, upd_evt, cmp_evt;
  logic [2:0]       mode;
  logic [CNT_W-1:0] cnt_load_val, div_sh, reload, cmp_sh, cmp_act, cnt;

  tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .upd_evt, .cmp_evt, .cnt_val(cnt),
    .run, .force_upd, .cnt_load, .cnt_load_val,
    .div_sh, .reload, .cmp_sh, .mode, .preload, .outen,
    .irq(irq_o)
  );

  tmr_prescaler #(.CNT_W(CNT_W)) u_presc (
    .clk, .rst_n, .run, .upd_evt, .div_sh, .tick
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk, .rst_n, .tick, .force_upd, .cnt_load, .cnt_load_val,
    .reload, .cmp_act, .cnt, .upd_evt, .cmp_evt
  );

  tmr_pwm #(.CNT_W(CNT_W)) u_pwm (
    .clk, .rst_n, .upd_evt, .preload, .outen, .mode,
    .cmp_sh, .cnt, .cmp_act, .pwm(pwm_o)
  );

endmodule

// File: tb/test_gp_pwm_timer.sv
`timescale 1ns/1ps
module test_gp_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_o, pwm_o;

  gp_pwm_timer i_gp_pwm_timer (.clk, .rst_n, .bus_addr, .bus_we, .bus_wdata,
                               .bus_rdata, .irq_o, .pwm_o);

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  logic [7:0] watch = 8'h14;
  bit chk_on = 1'b0;

  // behavioural reference state
  int m_run, m_quiet, m_inten, m_stat, m_mode, m_pre, m_outen;
  int m_divsh, m_divact, m_phase, m_reload, m_cmpsh, m_cmpact, m_cnt;

  always @(posedge clk or negedge rst_n) begin
    int wr, a, d, tick, adv, wrap, force_u, upd, nxt, hit;
    if (!rst_n) begin
      m_run = 0; m_quiet = 0; m_inten = 0; m_stat = 0; m_mode = 0; m_pre = 0;
      m_outen = 0; m_divsh = 0; m_divact = 0; m_phase = 0; m_reload = 0;
      m_cmpsh = 0; m_cmpact = 0; m_cnt = 0;
    end else begin
      wr = bus_we; a = bus_addr; d = bus_wdata;
      tick = m_run && (m_phase == m_divact);
      adv = tick && (m_reload != 0);
      wrap = adv && (m_cnt >= m_reload);
      force_u = wr && (a == 'h0C) && d[0];
      upd = wrap || force_u;
      nxt = wrap ? 0 : ((m_cnt + 1) & 'hFFFF);
      hit = adv && (nxt == m_cmpact);
      // compare register
      if (!m_pre || upd) m_cmpact = m_cmpsh;
      // divider
      if (upd) begin m_phase = 0; m_divact = m_divsh; end
      else if (m_run) m_phase = (m_phase == m_divact) ? 0 : m_phase + 1;
      // counter
      if (force_u) m_cnt = 0;
      else if (wr && a == 'h14) m_cnt = d & 'hFFFF;
      else if (adv) m_cnt = nxt;
      // flags
      if (wr && a == 'h08) m_stat = m_stat & d & 3;
      m_stat = m_stat | (hit ? 2 : 0) | ((upd && !m_quiet) ? 1 : 0);
      if (wr) begin
        case (a)
          'h00: begin m_run = d & 1; m_quiet = (d >> 1) & 1; end
          'h04: m_inten = d & 3;
          'h10: begin m_mode = d & 7; m_pre = (d >> 3) & 1; m_outen = (d >> 4) & 1; end
          'h18: m_divsh = d & 'hFFFF;
          'h1C: m_reload = d & 'hFFFF;
          'h20: m_cmpsh = d & 'hFFFF;
          default: ;
        endcase
      end
    end
  end

  function automatic int exp_rdata(int a);
    case (a)
      'h00: return m_run | (m_quiet << 1);
      'h04: return m_inten;
      'h08: return m_stat;
      'h10: return m_mode | (m_pre << 3) | (m_outen << 4);
      'h14: return m_cnt;
      'h18: return m_divsh;
      'h1C: return m_reload;
      'h20: return m_cmpsh;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_pwm();
    if (!m_outen) return 0;
    if (m_mode == 6) return int'(m_cnt < m_cmpact);
    if (m_mode == 7) return int'(m_cnt >= m_cmpact);
    return 0;
  endfunction

  always @(negedge clk) begin
    int er, ei, ep;
    #1;
    if (chk_on) begin
      er = exp_rdata(int'(bus_addr));
      ei = ((m_stat & m_inten) != 0) ? 1 : 0;
      ep = exp_pwm();
      checks += 3;
      if (bus_rdata !== er) begin
        fails++;
        $display("FAIL %s rdata @%h actual=%h expected=%h", cur_req, bus_addr, bus_rdata, er);
      end
      if (irq_o !== ei[0]) begin
        fails++;
        $display("FAIL %s irq actual=%b expected=%0d", cur_req, irq_o, ei);
      end
      if (pwm_o !== ep[0]) begin
        fails++;
        $display("FAIL %s pwm actual=%b expected=%0d", cur_req, pwm_o, ep);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = watch; bus_wdata = 32'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic look(input logic [7:0] a, input int n);
    watch = a;
    @(negedge clk);
    bus_addr = a;
    idle(n);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    chk_on = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values on every register
    cur_req = "R1";
    for (int a = 0; a <= 'h24; a += 4) look(8'(a), 1);

    // R2: readback, full replacement, EVGEN and unmapped read zero
    cur_req = "R2";
    wr(8'h04, 32'hFFFF_FFFF); look(8'h04, 1);
    wr(8'h04, 32'h0000_0002); look(8'h04, 1);
    wr(8'h10, 32'h0000_001F); look(8'h10, 1);
    wr(8'h10, 32'h0000_0001); look(8'h10, 1);
    wr(8'h1C, 32'h0001_ABCD); look(8'h1C, 1);
    wr(8'h20, 32'h0000_1234); look(8'h20, 1);
    wr(8'h18, 32'h0000_0055); look(8'h18, 1);
    look(8'h0C, 1); look(8'h24, 1); look(8'h03, 1); look(8'hFC, 1);
    wr(8'h04, 0); wr(8'h10, 0); wr(8'h20, 0);

    // R3: divide by 3, then a buffered change to divide by 1
    cur_req = "R3";
    watch = 8'h14;
    wr(8'h18, 2); wr(8'h1C, 7);
    cur_req = "R7";
    wr(8'h0C, 1);
    cur_req = "R3";
    wr(8'h00, 1); idle(40);
    wr(8'h18, 0); idle(30);
    wr(8'h18, 4); idle(40);

    // R4: zero reload halts counting, then a short reload
    cur_req = "R4";
    wr(8'h1C, 0); idle(15);
    wr(8'h18, 0); wr(8'h0C, 1);
    wr(8'h1C, 3); idle(20);

    // R5 and R10: update flag and interrupt, then quiet mode
    cur_req = "R5";
    wr(8'h04, 1); look(8'h08, 10);
    wr(8'h08, 0); idle(10);
    wr(8'h00, 3); wr(8'h08, 0); idle(20);
    wr(8'h0C, 1); idle(5);
    cur_req = "R10";
    wr(8'h04, 0); wr(8'h00, 1); idle(10);

    // R6: AND-clear, colliding with hardware sets
    cur_req = "R6";
    wr(8'h20, 2); wr(8'h04, 3);
    for (int i = 0; i < 12; i++) begin
      wr(8'h08, 32'h2);
      wr(8'h08, 32'h0);
      idle(i % 3);
    end
    wr(8'h08, 32'hFFFF_FFFE); idle(3);

    // R7: forced update mid-period, and a no-op EVGEN write
    cur_req = "R7";
    wr(8'h1C, 9); wr(8'h18, 3); look(8'h14, 6);
    wr(8'h0C, 1); idle(7);
    wr(8'h0C, 32'hFFFF_FFFE); idle(7);
    wr(8'h0C, 1); idle(20);

    // R8: direct loads, including above the reload value
    cur_req = "R8";
    wr(8'h14, 2); idle(3);
    wr(8'h14, 32'h0003_00F0); idle(12);

    // R9: compare flag
    cur_req = "R9";
    wr(8'h18, 0); wr(8'h0C, 1); wr(8'h20, 0); wr(8'h08, 0);
    look(8'h08, 12);
    wr(8'h20, 5); wr(8'h08, 0); idle(15);

    // R11: PWM modes and output enable
    cur_req = "R11";
    wr(8'h04, 0); watch = 8'h14;
    wr(8'h1C, 9); wr(8'h20, 4);
    wr(8'h10, 32'h16); idle(30);
    wr(8'h10, 32'h17); idle(30);
    wr(8'h10, 32'h15); idle(15);
    wr(8'h10, 32'h07); idle(15);
    wr(8'h10, 32'h16); wr(8'h20, 0); idle(15);
    wr(8'h20, 10); idle(15);

    // R12: preloaded compare waits for update
    cur_req = "R12";
    wr(8'h18, 1); wr(8'h0C, 1);
    wr(8'h10, 32'h1E); wr(8'h20, 3); idle(4);
    wr(8'h20, 8); idle(30);
    wr(8'h20, 2); idle(5); wr(8'h0C, 1); idle(20);
    wr(8'h10, 32'h16); wr(8'h20, 6); idle(20);

    finish_run();
  end
endmodule